// File: doc/BRIEF.md
# Power-Up Boot Vector Sequencer

This block decides how a 16-bit processor starts after power-up or reset. On the first clock after reset is released it captures a set of board straps: a two-bit start-up option, four high-order boot-address bits and a halt-enable bit. It keeps these values until the next reset. The option picks one of four start-up policies:
- read the start PC and PS from two fixed low-memory words through a simple request/acknowledge read port;
- enter the console/debug mode;
- load a fixed ROM start address;
- build the start address from the address straps.

When PC and PS are ready, a one-cycle start pulse tells the execution core to begin. In debug mode no start pulse is issued. The debug flag stays high until an external continue input releases it.

After start, a halt request is handled by the captured halt-enable strap. It either raises a stop pulse or raises a trap pulse together with trap vector 4. Instruction execution and the console itself are outside the block.

Top module: `boot_vector_seq`

## Requirements
- R1: While `rst` is high, and on the first sample after it, `pc_out`, `ps_out`, `mem_req`, `start_pulse`, `debug_mode`, `halt_stop`, `halt_trap` and `trap_vec` are all zero. The straps are captured on the first rising edge with `rst` low. Later strap changes have no effect until the next reset.
- R2: With `boot_opt` = 2'b11, the block first reads word address 16'h0014 (octal 024) and loads PC from the returned data. It then reads 16'h0016 (octal 026) and loads PS. The request is raised in the cycle after the second edge following reset release, and each read completes on the edge where `mem_ack` is high.
- R3: With `boot_opt` = 2'b10, `debug_mode` rises in the cycle after the second edge following reset release, with PS = 0. It stays high, with no start pulse, until `continue_in` is sampled high. One cycle later it is low, still with no start pulse.
- R4: With `boot_opt` = 2'b01, PC = 16'hF600 (octal 0173000) and PS = 16'h00E0 (octal 340).
- R5: With `boot_opt` = 2'b00, PC = {`boot_addr_strap`[3:0], 12'h000}, where strap bit 3 is address bit 15. PS = 16'h00E0.
- R6: `start_pulse` is high for exactly one cycle. For the fixed policies (R4, R5) this is the cycle after the second edge following reset release. For the memory policy (R2) it is the cycle after the edge that accepts the second acknowledge.
- R7: `pc_out` and `ps_out` keep their values from the start pulse until the next reset.
- R8: After start, a `halt_req` sampled high gives a one-cycle response in the next cycle. It is `halt_stop` when the captured `halt_en_strap` is 1, or `halt_trap` with `trap_vec` = 16'h0004 when it is 0. Before start, including in debug mode, `halt_req` has no effect.
- R9: Once `mem_req` is high, it and `mem_addr` hold steady until the edge on which `mem_ack` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_opt | input | 2 | Start-up option strap, bit 1 is option bit 2 |
| boot_addr_strap | input | 4 | Boot address bits 15..12 |
| halt_en_strap | input | 1 | 1: halt request stops, 0: traps to vector 4 |
| halt_req | input | 1 | Halt request from the system |
| continue_in | input | 1 | Releases debug mode |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 16 | Read data |
| pc_out | output | 16 | Start program counter |
| ps_out | output | 16 | Start processor status |
| start_pulse | output | 1 | One-cycle start strobe |
| debug_mode | output | 1 | Console/debug mode flag |
| halt_stop | output | 1 | Halt response: stop |
| halt_trap | output | 1 | Halt response: trap |
| trap_vec | output | 16 | Trap vector, 4 while `halt_trap` is high |

## Verification
All results are registered. Strap capture happens on the first edge after reset release, and the policy decision on the second. The fixed-policy start pulse, the debug flag and the first read request are therefore checked at the falling edge after that second edge. Each memory read advances one edge after the acknowledge is sampled, so the bench drives `mem_ack` at a falling edge and checks the next request or the start pulse at the following falling edge. Halt responses and the release from debug mode appear one cycle after their input, and every check samples on the falling edge, away from the edge that updates the design.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    localparam int unsigned WORD_W  = 16;
    localparam int unsigned STRAP_W = 4;
    localparam int unsigned LOW_W   = WORD_W - STRAP_W;

    localparam logic [WORD_W-1:0] VEC_PC_ADDR = 16'o024;
    localparam logic [WORD_W-1:0] VEC_PS_ADDR = 16'o026;
    localparam logic [WORD_W-1:0] ROM_PC      = 16'o173000;
    localparam logic [WORD_W-1:0] RUN_PS      = 16'o340;
    localparam logic [WORD_W-1:0] HALT_VEC    = 16'o4;

    typedef enum logic [1:0] {
        MODE_STRAP   = 2'b00,
        MODE_ROM     = 2'b01,
        MODE_CONSOLE = 2'b10,
        MODE_VECTOR  = 2'b11
    } boot_mode_e;

    typedef enum logic [2:0] {
        ST_SAMPLE,
        ST_DISPATCH,
        ST_FETCH_PC,
        ST_FETCH_PS,
        ST_LAUNCH,
        ST_CONSOLE,
        ST_RUN
    } seq_state_e;

    typedef struct packed {
        boot_mode_e         mode;
        logic [STRAP_W-1:0] addr_hi;
        logic               halt_en;
    } strap_cfg_t;

    typedef struct packed {
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] ps;
    } start_ctx_t;

    function automatic logic [WORD_W-1:0] strap_to_addr(input logic [STRAP_W-1:0] hi);
        return {hi, {LOW_W{1'b0}}};
    endfunction

endpackage

// File: rtl/strap_latch.sv
module strap_latch
    import boot_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               capture,
    input  logic [1:0]         opt_in,
    input  logic [STRAP_W-1:0] addr_in,
    input  logic               halt_en_in,
    output strap_cfg_t         cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (capture) begin
            cfg.mode    <= boot_mode_e'(opt_in);
            cfg.addr_hi <= addr_in;
            cfg.halt_en <= halt_en_in;
        end
    end
endmodule

// File: rtl/boot_fsm.sv
module boot_fsm
    import boot_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  strap_cfg_t        cfg,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              continue_in,
    output logic              capture,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    output start_ctx_t        ctx,
    output logic              start_pulse,
    output logic              debug_mode,
    output logic              running
);
    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_SAMPLE;
            ctx   <= '0;
        end else begin
            unique case (state)
                ST_SAMPLE:   state <= ST_DISPATCH;
                ST_DISPATCH: begin
                    unique case (cfg.mode)
                        MODE_VECTOR:  state <= ST_FETCH_PC;
                        MODE_CONSOLE: begin
                            ctx.ps <= '0;
                            state  <= ST_CONSOLE;
                        end
                        MODE_ROM: begin
                            ctx.pc <= ROM_PC;
                            ctx.ps <= RUN_PS;
                            state  <= ST_LAUNCH;
                        end
                        default: begin
                            ctx.pc <= strap_to_addr(cfg.addr_hi);
                            ctx.ps <= RUN_PS;
                            state  <= ST_LAUNCH;
                        end
                    endcase
                end
                ST_FETCH_PC: if (mem_ack) begin
                    ctx.pc <= mem_rdata;
                    state  <= ST_FETCH_PS;
                end
                ST_FETCH_PS: if (mem_ack) begin
                    ctx.ps <= mem_rdata;
                    state  <= ST_LAUNCH;
                end
                ST_LAUNCH:   state <= ST_RUN;
                ST_CONSOLE:  if (continue_in) state <= ST_RUN;
                default:     state <= ST_RUN;
            endcase
        end
    end

    always_comb begin
        capture     = (state == ST_SAMPLE);
        mem_req     = (state == ST_FETCH_PC) || (state == ST_FETCH_PS);
        mem_addr    = (state == ST_FETCH_PS) ? VEC_PS_ADDR :
                      (state == ST_FETCH_PC) ? VEC_PC_ADDR : '0;
        start_pulse = (state == ST_LAUNCH);
        debug_mode  = (state == ST_CONSOLE);
        running     = (state == ST_RUN);
    end
endmodule

// File: rtl/halt_ctl.sv
module halt_ctl
    import boot_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              running,
    input  logic              halt_en,
    input  logic              halt_req,
    output logic              halt_stop,
    output logic              halt_trap,
    output logic [WORD_W-1:0] trap_vec
);
    always_ff @(posedge clk) begin
        if (rst) begin
            halt_stop <= 1'b0;
            halt_trap <= 1'b0;
        end else begin
            halt_stop <= running & halt_req & halt_en;
            halt_trap <= running & halt_req & ~halt_en;
        end
    end

    assign trap_vec = halt_trap ? HALT_VEC : '0;
endmodule

// File: rtl/boot_vector_seq.sv
module boot_vector_seq
    import boot_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         boot_opt,
    input  logic [STRAP_W-1:0] boot_addr_strap,
    input  logic               halt_en_strap,
    input  logic               halt_req,
    input  logic               continue_in,
    output logic               mem_req,
    output logic [WORD_W-1:0]  mem_addr,
    input  logic               mem_ack,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic [WORD_W-1:0]  pc_out,
    output logic [WORD_W-1:0]  ps_out,
    output logic               start_pulse,
    output logic               debug_mode,
    output logic               halt_stop,
    output logic               halt_trap,
    output logic [WORD_W-1:0]  trap_vec
);
    strap_cfg_t cfg;
    start_ctx_t ctx;
    logic       capture;
    logic       running;

    strap_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .capture    (capture),
        .opt_in     (boot_opt),
        .addr_in    (boot_addr_strap),
        .halt_en_in (halt_en_strap),
        .cfg        (cfg)
    );

    boot_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .continue_in (continue_in),
        .capture     (capture),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .ctx         (ctx),
        .start_pulse (start_pulse),
        .debug_mode  (debug_mode),
        .running     (running)
    );

    halt_ctl u_halt (
        .clk       (clk),
        .rst       (rst),
        .running   (running),
        .halt_en   (cfg.halt_en),
        .halt_req  (halt_req),
        .halt_stop (halt_stop),
        .halt_trap (halt_trap),
        .trap_vec  (trap_vec)
    );

    assign pc_out = ctx.pc;
    assign ps_out = ctx.ps;
endmodule

// File: rtl/boot_vector_seq_chk.sv
module boot_vector_seq_chk
    import boot_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic [WORD_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic [WORD_W-1:0] pc_out,
    input logic [WORD_W-1:0] ps_out,
    input logic              start_pulse,
    input logic              debug_mode,
    input logic              halt_stop,
    input logic              halt_trap,
    input logic [WORD_W-1:0] trap_vec
);
    logic launched;

    always_ff @(posedge clk) begin
        if (rst)              launched <= 1'b0;
        else if (start_pulse) launched <= 1'b1;
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);                                    // R6
    AST_CTX_STABLE: assert property (@(posedge clk) disable iff (rst)
        (launched || start_pulse) |=> ($stable(pc_out) && $stable(ps_out))); // R7
    AST_DEBUG_NO_START: assert property (@(posedge clk) disable iff (rst)
        debug_mode |-> !start_pulse);                                     // R3
    AST_DEBUG_PS_ZERO: assert property (@(posedge clk) disable iff (rst)
        debug_mode |-> (ps_out == '0));                                   // R3
    AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr == VEC_PC_ADDR || mem_addr == VEC_PS_ADDR)); // R2
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));        // R9
    AST_HALT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(halt_stop && halt_trap));                                       // R8
    AST_TRAP_VEC: assert property (@(posedge clk) disable iff (rst)
        halt_trap |-> (trap_vec == HALT_VEC));                            // R8
    AST_NO_HALT_BEFORE_RUN: assert property (@(posedge clk) disable iff (rst)
        !launched |-> !(halt_stop || halt_trap));                         // R8
endmodule

bind boot_vector_seq boot_vector_seq_chk chk_i (.*);

// File: tb/boot_vector_seq_tb_top.sv
module boot_vector_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  boot_opt = 2'b00;
    logic [3:0]  boot_addr_strap = 4'h0;
    logic        halt_en_strap = 1'b0;
    logic        halt_req = 1'b0;
    logic        continue_in = 1'b0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = 16'h0;
    logic [15:0] pc_out, ps_out, trap_vec;
    logic        start_pulse, debug_mode, halt_stop, halt_trap;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_vector_seq dut_i (
        .clk(clk), .rst(rst), .boot_opt(boot_opt), .boot_addr_strap(boot_addr_strap),
        .halt_en_strap(halt_en_strap), .halt_req(halt_req), .continue_in(continue_in),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .pc_out(pc_out), .ps_out(ps_out), .start_pulse(start_pulse), .debug_mode(debug_mode),
        .halt_stop(halt_stop), .halt_trap(halt_trap), .trap_vec(trap_vec)
    );

    function automatic logic [15:0] exp_pc(input logic [1:0] opt, input logic [3:0] s,
                                           input logic [15:0] d0);
        case (opt)
            2'b11:   return d0;
            2'b01:   return 16'hF600;
            2'b00:   return {s, 12'h000};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] exp_ps(input logic [1:0] opt, input logic [15:0] d1);
        case (opt)
            2'b11:   return d1;
            2'b10:   return 16'h0000;
            default: return 16'h00E0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_boot(input logic [1:0] opt, input logic [3:0] s, input logic hen,
                            input logic [15:0] d0, input logic [15:0] d1,
                            input int lat0, input int lat1);
        logic [15:0] pc_e, ps_e;
        pc_e = exp_pc(opt, s, d0);
        ps_e = exp_ps(opt, d1);
        @(negedge clk);
        rst = 1'b1; boot_opt = opt; boot_addr_strap = s; halt_en_strap = hen;
        halt_req = 1'b0; continue_in = 1'b0; mem_ack = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 reset pc", pc_out, 16'h0);
        chk("R1 reset ps", ps_out, 16'h0);
        chk("R1 reset flags", {12'h0, mem_req, start_pulse, debug_mode, halt_stop | halt_trap}, 16'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 first cycle idle", {14'h0, start_pulse, mem_req}, 16'h0);
        boot_opt = ~opt; boot_addr_strap = ~s; halt_en_strap = ~hen;   // R1 must be ignored
        @(negedge clk);
        if (opt == 2'b10) begin
            chk("R3 debug high", {15'h0, debug_mode}, 16'h1);
            chk("R3 ps zero", ps_out, 16'h0);
            halt_req = 1'b1;
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk("R3 debug held no start", {14'h0, debug_mode, start_pulse}, 16'h2);
                chk("R8 halt ignored in debug", {14'h0, halt_stop, halt_trap}, 16'h0);
            end
            halt_req = 1'b0;
            continue_in = 1'b1;
            @(negedge clk);
            continue_in = 1'b0;
            chk("R3 released no start", {14'h0, debug_mode, start_pulse}, 16'h0);
            return;
        end
        if (opt == 2'b11) begin
            chk("R2 first read addr", {mem_req, mem_addr[14:0]}, 16'h8014);
            for (int i = 0; i < lat0; i++) begin
                @(negedge clk);
                chk("R9 pc request held", {mem_req, mem_addr[14:0]}, 16'h8014);
            end
            mem_ack = 1'b1; mem_rdata = d0;
            @(negedge clk);
            mem_ack = 1'b0; mem_rdata = 16'h0;
            chk("R2 second read addr", {mem_req, mem_addr[14:0]}, 16'h8016);
            chk("R6 no early start", {15'h0, start_pulse}, 16'h0);
            for (int i = 0; i < lat1; i++) begin
                @(negedge clk);
                chk("R9 ps request held", {mem_req, mem_addr[14:0]}, 16'h8016);
            end
            mem_ack = 1'b1; mem_rdata = d1;
            @(negedge clk);
            mem_ack = 1'b0; mem_rdata = 16'h0;
        end
        chk("R6 start high", {14'h0, start_pulse, mem_req}, 16'h2);
        chk(opt == 2'b11 ? "R2 pc" : (opt == 2'b01 ? "R4 pc" : "R5 pc"), pc_out, pc_e);
        chk(opt == 2'b11 ? "R2 ps" : (opt == 2'b01 ? "R4 ps" : "R5 ps"), ps_out, ps_e);
        @(negedge clk);
        chk("R6 start single", {15'h0, start_pulse}, 16'h0);
        halt_req = 1'b1;
        @(negedge clk);
        halt_req = 1'b0;
        chk("R8 halt response", {14'h0, halt_stop, halt_trap}, hen ? 16'h2 : 16'h1);
        chk("R8 trap vector", trap_vec, hen ? 16'h0 : 16'h0004);
        @(negedge clk);
        chk("R8 halt one cycle", {14'h0, halt_stop, halt_trap}, 16'h0);
        chk("R7 pc held", pc_out, pc_e);
        chk("R7 ps held", ps_out, ps_e);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd5417));
        run_boot(2'b11, 4'h0, 1'b1, 16'hFFFF, 16'h0000, 0, 0);
        run_boot(2'b11, 4'h5, 1'b0, 16'h1234, 16'hABCD, 3, 1);
        run_boot(2'b10, 4'hF, 1'b1, 16'h0, 16'h0, 0, 0);
        run_boot(2'b01, 4'hA, 1'b0, 16'h0, 16'h0, 0, 0);
        run_boot(2'b00, 4'h8, 1'b1, 16'h0, 16'h0, 0, 0);
        run_boot(2'b00, 4'h1, 1'b0, 16'h0, 16'h0, 0, 0);
        for (int n = 0; n < 40; n++) begin
            run_boot(2'($urandom), 4'($urandom), 1'($urandom), 16'($urandom),
                     16'($urandom), int'($urandom % 4), int'($urandom % 4));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule